// File: doc/BRIEF.md
# Vector Accumulator Slot with Offset Read-Out

This block is one accumulator slot in a vector datapath. It holds two registers of `WORD_W` bits (32 by default). The operand register takes a vector that is written in right-justified. The vector is read back through an offset decoder, which moves the operand toward the high end by a programmable amount `p`. Any bit that would move past the top of the word is dropped, and the positions below `p` are filled with zeros. A vector placed at the low end can therefore be lined up anywhere in the word, which limits a vector to at most `WORD_W` elements.

The second register is the sum register. It is loaded only from the operand register and has its own registered output bus. Three single-cycle commands act on it: clear it, add the operand into it, or copy the operand into it. A reduction is done by loading the elements one after another and issuing an add after each load. The addition wraps modulo 2^`WORD_W`.

Top module: `vec_accum_slot`

## Requirements
- R1: After a synchronous active-high reset, both the operand register and the sum register hold zero. As a result, `sum_out` reads 0 and `shifted_out` reads 0 for any offset.
- R2: When `a_load` is high at a rising edge, the operand register takes `a_din`. When `a_load` is low, the operand register keeps its value.
- R3: `shifted_out` equals the operand shifted left by `shift_p`. Result bits below index `shift_p` are 0, and operand bits that would land at index `WORD_W` or above are discarded. The output follows changes in `shift_p` or in the operand in the same cycle, without waiting for a clock edge.
- R4: When `cmd_clear` is high at a rising edge, `sum_out` is 0 after that edge.
- R5: When `cmd_add` is high and `cmd_clear` is low at a rising edge, `sum_out` becomes the previous sum plus the operand, modulo 2^`WORD_W`.
- R6: When `cmd_copy` is high and both `cmd_clear` and `cmd_add` are low at a rising edge, `sum_out` becomes the operand value.
- R7: When several commands are high in the same cycle, clear wins over add, and add wins over copy.
- R8: When a load and an add happen in the same cycle, the add uses the operand value from before the load.
- R9: When no command is high, `sum_out` keeps its value, including in cycles that load the operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| a_load | input | 1 | Write enable for the operand register |
| a_din | input | WORD_W | Right-justified vector data for the operand register |
| shift_p | input | SHIFT_W | Left offset applied on read-out (5 bits by default) |
| cmd_clear | input | 1 | Zero the sum register |
| cmd_add | input | 1 | Add the operand into the sum register |
| cmd_copy | input | 1 | Copy the operand into the sum register |
| shifted_out | output | WORD_W | Operand after the offset shift, combinational |
| sum_out | output | WORD_W | Sum register contents, registered |

## Verification
The bench sweeps the offset across 0, 1, a middle value and 31, using all-ones and sparse operands. A decoder that shifts the wrong way, rotates instead of discarding, or leaves junk in the vacated low bits would show a mismatch at the extreme offsets. A reduction is driven past 2^32 to confirm that the sum wraps. All combinations of simultaneous commands are applied, so that an inverted priority would leave a stale or copied sum where zero or a sum is expected. A load issued together with an add checks that the add uses the old operand; a design that forwards the new operand would report the wrong total.

// File: rtl/vacc_pkg.sv
package vacc_pkg;
  typedef enum logic [1:0] {
    B_HOLD  = 2'd0,
    B_CLEAR = 2'd1,
    B_ADD   = 2'd2,
    B_COPY  = 2'd3
  } b_op_e;
endpackage

// File: rtl/vacc_cmd_arb.sv
// Resolves the three sum-register commands into one operation (R7 priority).
module vacc_cmd_arb
  import vacc_pkg::*;
(
  input  logic  cmd_clear,
  input  logic  cmd_add,
  input  logic  cmd_copy,
  output b_op_e op
);
  always_comb begin
    if (cmd_clear)     op = B_CLEAR;
    else if (cmd_add)  op = B_ADD;
    else if (cmd_copy) op = B_COPY;
    else               op = B_HOLD;
  end
endmodule

// File: rtl/vacc_offset_dec.sv
// Left shift by p, built as one select per output bit; high spill-over is discarded.
module vacc_offset_dec #(
  parameter int WORD_W  = 32,
  parameter int SHIFT_W = $clog2(WORD_W)
) (
  input  logic [WORD_W-1:0]  din,
  input  logic [SHIFT_W-1:0] p,
  output logic [WORD_W-1:0]  dout
);
  for (genvar i = 0; i < WORD_W; i++) begin : g_bit
    logic bit_v;
    always_comb begin
      bit_v = 1'b0;
      for (int k = 0; k <= i; k++) begin
        if (p == SHIFT_W'(i - k)) bit_v = din[k];
      end
    end
    assign dout[i] = bit_v;
  end
endmodule

// File: rtl/vacc_sum_reg.sv
// Sum register: clear, wrapping add, copy, or hold.
module vacc_sum_reg
  import vacc_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  b_op_e             op,
  input  logic [WORD_W-1:0] operand,
  output logic [WORD_W-1:0] sum_q
);
  logic [WORD_W-1:0] sum_d;

  always_comb begin
    unique case (op)
      B_CLEAR: sum_d = '0;
      B_ADD:   sum_d = sum_q + operand;
      B_COPY:  sum_d = operand;
      default: sum_d = sum_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) sum_q <= '0;
    else     sum_q <= sum_d;
  end
endmodule

// File: rtl/vec_accum_slot.sv
module vec_accum_slot
  import vacc_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int SHIFT_W = $clog2(WORD_W)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               a_load,
  input  logic [WORD_W-1:0]  a_din,
  input  logic [SHIFT_W-1:0] shift_p,
  input  logic               cmd_clear,
  input  logic               cmd_add,
  input  logic               cmd_copy,
  output logic [WORD_W-1:0]  shifted_out,
  output logic [WORD_W-1:0]  sum_out
);
  logic [WORD_W-1:0] a_q;
  b_op_e             op;

  // Operand register; the sum register samples its old value on a shared edge (R8).
  always_ff @(posedge clk) begin
    if (rst)         a_q <= '0;
    else if (a_load) a_q <= a_din;
  end

  vacc_cmd_arb u_arb (
    .cmd_clear (cmd_clear),
    .cmd_add   (cmd_add),
    .cmd_copy  (cmd_copy),
    .op        (op)
  );

  vacc_offset_dec #(.WORD_W(WORD_W), .SHIFT_W(SHIFT_W)) u_dec (
    .din  (a_q),
    .p    (shift_p),
    .dout (shifted_out)
  );

  vacc_sum_reg #(.WORD_W(WORD_W)) u_sum (
    .clk     (clk),
    .rst     (rst),
    .op      (op),
    .operand (a_q),
    .sum_q   (sum_out)
  );
endmodule

// File: rtl/vacc_checks.sv
module vacc_checks #(
  parameter int WORD_W  = 32,
  parameter int SHIFT_W = $clog2(WORD_W)
) (
  input logic               clk,
  input logic               rst,
  input logic               a_load,
  input logic [WORD_W-1:0]  a_din,
  input logic [SHIFT_W-1:0] shift_p,
  input logic               cmd_clear,
  input logic               cmd_add,
  input logic               cmd_copy,
  input logic [WORD_W-1:0]  a_q,
  input logic [WORD_W-1:0]  shifted_out,
  input logic [WORD_W-1:0]  sum_out
);
  localparam logic [WORD_W-1:0] ONES = {WORD_W{1'b1}};

  a_r1_reset_sum: assert property (@(posedge clk) rst |=> sum_out == '0);
  a_r1_reset_a:   assert property (@(posedge clk) rst |=> a_q == '0);

  a_r2_load: assert property (@(posedge clk) disable iff (rst)
    a_load |=> a_q == $past(a_din));
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !a_load |=> $stable(a_q));

  a_r3_low_zero: assert property (@(posedge clk) disable iff (rst)
    (shifted_out & ~(ONES << shift_p)) == '0);
  a_r3_body: assert property (@(posedge clk) disable iff (rst)
    (shifted_out >> shift_p) == (a_q & (ONES >> shift_p)));

  a_r4_clear: assert property (@(posedge clk) disable iff (rst)
    cmd_clear |=> sum_out == '0);
  // R5 and R7: add wins over copy
  a_r5_add: assert property (@(posedge clk) disable iff (rst)
    (cmd_add && !cmd_clear) |=> sum_out == $past(sum_out) + $past(a_q));
  a_r6_copy: assert property (@(posedge clk) disable iff (rst)
    (cmd_copy && !cmd_add && !cmd_clear) |=> sum_out == $past(a_q));
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (!cmd_copy && !cmd_add && !cmd_clear) |=> $stable(sum_out));
endmodule

bind vec_accum_slot vacc_checks #(.WORD_W(WORD_W), .SHIFT_W(SHIFT_W)) u_vacc_checks (
  .clk         (clk),
  .rst         (rst),
  .a_load      (a_load),
  .a_din       (a_din),
  .shift_p     (shift_p),
  .cmd_clear   (cmd_clear),
  .cmd_add     (cmd_add),
  .cmd_copy    (cmd_copy),
  .a_q         (a_q),
  .shifted_out (shifted_out),
  .sum_out     (sum_out)
);

// File: tb/test_vec_accum_slot.sv
`timescale 1ns/1ps
module test_vec_accum_slot;
  localparam int W  = 32;
  localparam int SW = 5;

  logic          clk = 1'b0;
  logic          rst;
  logic          a_load;
  logic [W-1:0]  a_din;
  logic [SW-1:0] shift_p;
  logic          cmd_clear, cmd_add, cmd_copy;
  logic [W-1:0]  shifted_out, sum_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  logic [W-1:0] m_a, m_b;

  always #4 clk = ~clk;

  vec_accum_slot #(.WORD_W(W), .SHIFT_W(SW)) i_vec_accum_slot (
    .clk(clk), .rst(rst), .a_load(a_load), .a_din(a_din), .shift_p(shift_p),
    .cmd_clear(cmd_clear), .cmd_add(cmd_add), .cmd_copy(cmd_copy),
    .shifted_out(shifted_out), .sum_out(sum_out)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One clock with the given inputs; the model follows the requirements.
  task automatic cyc(input logic ld, input logic [W-1:0] d,
                     input logic clr, input logic add, input logic cpy);
    logic [W-1:0] old_a;
    a_load = ld; a_din = d; cmd_clear = clr; cmd_add = add; cmd_copy = cpy;
    old_a = m_a;
    @(posedge clk);
    if (ld) m_a = d;
    if (clr)      m_b = '0;
    else if (add) m_b = m_b + old_a;
    else if (cpy) m_b = old_a;
    @(negedge clk);
    a_load = 0; cmd_clear = 0; cmd_add = 0; cmd_copy = 0;
  endtask

  task automatic peek_a(input string req);
    shift_p = '0; #1;
    chk(req, shifted_out, m_a);
  endtask

  task automatic t_reset;
    rst = 1; a_load = 0; a_din = '0; shift_p = 5'd7;
    cmd_clear = 0; cmd_add = 0; cmd_copy = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    m_a = '0; m_b = '0;
    chk("R1 sum", sum_out, '0);
    chk("R1 shift", shifted_out, '0);
  endtask

  task automatic t_load_shift;
    cyc(1, 32'hFFFF_FFFF, 0, 0, 0);
    peek_a("R2 load");
    foreach (shift_p_list[i]) begin
      shift_p = shift_p_list[i]; #1;
      chk("R3 ones", shifted_out, m_a << shift_p_list[i]);
    end
    cyc(1, 32'h0000_002D, 0, 0, 0);
    shift_p = 5'd31; #1;
    chk("R3 p31 sparse", shifted_out, 32'h8000_0000);
    shift_p = 5'd28; #1;
    chk("R3 p28 spill", shifted_out, 32'hD000_0000);
    shift_p = 5'd4; #1;
    chk("R3 p4", shifted_out, 32'h0000_02D0);
    cyc(0, 32'h1234_5678, 0, 0, 0);
    peek_a("R2 hold");
  endtask

  logic [SW-1:0] shift_p_list [4] = '{5'd0, 5'd1, 5'd13, 5'd31};

  task automatic t_reduce;
    cyc(0, '0, 1, 0, 0);
    chk("R4 clear", sum_out, '0);
    cyc(1, 32'd5, 0, 0, 0);
    cyc(0, '0, 0, 1, 0);
    chk("R5 add 5", sum_out, 32'd5);
    cyc(1, 32'd7, 0, 0, 0);
    cyc(0, '0, 0, 1, 0);
    chk("R5 add 12", sum_out, 32'd12);
    cyc(1, 32'hFFFF_FFFE, 0, 0, 0);
    cyc(0, '0, 0, 1, 0);
    chk("R5 wrap", sum_out, 32'd10);
    chk("R5 wrap model", sum_out, m_b);
  endtask

  task automatic t_copy;
    cyc(1, 32'hA5A5_0F0F, 0, 0, 0);
    cyc(0, '0, 0, 0, 1);
    chk("R6 copy", sum_out, 32'hA5A5_0F0F);
  endtask

  task automatic t_priority;
    cyc(1, 32'd3, 0, 0, 1);
    chk("R6 copy old A", sum_out, 32'hA5A5_0F0F);
    cyc(0, '0, 1, 1, 1);
    chk("R7 clear over all", sum_out, '0);
    cyc(0, '0, 0, 1, 1);
    chk("R7 add over copy", sum_out, 32'd3);
    cyc(0, '0, 0, 1, 1);
    chk("R7 add over copy twice", sum_out, 32'd6);
    cyc(0, '0, 1, 0, 1);
    chk("R7 clear over copy", sum_out, '0);
  endtask

  task automatic t_load_add;
    cyc(1, 32'd100, 0, 0, 0);
    cyc(1, 32'd1000, 0, 1, 0);
    chk("R8 add uses old A", sum_out, 32'd100);
    peek_a("R8 new A loaded");
    cyc(0, '0, 0, 1, 0);
    chk("R8 next add new A", sum_out, 32'd1100);
  endtask

  task automatic t_hold;
    cyc(1, 32'hDEAD_BEEF, 0, 0, 0);
    chk("R9 hold on load", sum_out, 32'd1100);
    cyc(0, '0, 0, 0, 0);
    chk("R9 hold idle", sum_out, m_b);
  endtask

  initial begin
    t_reset();
    t_load_shift();
    t_reduce();
    t_copy();
    t_priority();
    t_load_add();
    t_hold();
    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule